// File: doc/BRIEF.md
# Masked Bus Data Break Comparator

This block is the data-match stage of one hardware breakpoint channel. Software loads a 32-bit break value and a 32-bit ignore mask through a small register port. The block then watches a processor data bus and compares it against the break value. Only the bits whose mask bit is clear take part in the comparison.

A bus-select input chooses which bus is watched:
- a full-width internal bus;
- a 32-bit local bus;
- one of two 16-bit data-memory buses, each tied to a fixed half of the break value.

An operand size is programmed with the compare. It decides which lanes are compared:
- a longword uses every lane the bus carries;
- a word uses one 16-bit half;
- a byte compares the accessed byte against both bytes of that half, where software has placed the same byte twice.

For a dual-memory word move on the local bus, the upper half of the break value is compared against the upper bus lanes. A qualifying cycle raises a single-cycle hit pulse from a register, one clock later.

Top module: `brk_data_match`

## Requirements
- R1: After synchronous reset, the break value and the mask both read back as zero, and `hit_o` is low.
- R2: A write with `reg_wr_sel`=0 loads the break value and a write with `reg_wr_sel`=1 loads the mask. `reg_rd_data` shows the break value (`reg_rd_sel`=0) or the mask (`reg_rd_sel`=1), registered one clock after the select.
- R3: A mask bit of 1 removes that bit from the compare. A mask bit of 0 requires the bus bit to equal the break bit.
- R4: With `cfg_bus_sel`=00 (internal bus) and a longword size, all 32 bus bits are compared with break bits 31:0. A word size compares bus bits 15:0 with break bits 15:0.
- R5: With `cfg_bus_sel`=01, the 16 lines of `xa_data` are compared with break bits 31:16, and break bits 15:0 are ignored.
- R6: With `cfg_bus_sel`=10, the 16 lines of `xb_data` are compared with break bits 15:0, and break bits 31:16 are ignored.
- R7: With `cfg_bus_sel`=11 (local bus), the compare depends on size and the dual-move flag:
  - a longword compares all 32 bits;
  - a word compares bits 15:0 of bus and break value;
  - a word with `lb_dual_move`=1 compares bits 31:16 of both instead.
- R8: Size code 01 (byte) compares bus lines 7:0 of the selected 16-bit half against both byte lanes of the matching break half, each under its own mask bits.
- R9: With `cfg_data_en`=1 and size code 00 (any), no hit is produced.
- R10: Size codes are 00 any, 01 byte, 10 word and 11 longword. When the programmed size is not 00, a hit needs `bus_size` equal to `cfg_size`.
- R11: With `cfg_data_en`=0, the data condition counts as true. Only the valid and size conditions remain.
- R12: `hit_o` is high for exactly the one clock that follows each cycle with `bus_valid` high that meets all conditions. A cycle with `bus_valid` low never produces a hit.
- R13: A register write in the same cycle as a bus compare does not change that cycle's result. It applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 break value, 1 mask |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 1 | Readback select: 0 break value, 1 mask |
| reg_rd_data | output | 32 | Registered readback |
| cfg_data_en | input | 1 | Enables the data condition |
| cfg_size | input | 2 | Programmed operand size |
| cfg_bus_sel | input | 2 | Watched bus |
| bus_valid | input | 1 | A bus cycle is present |
| bus_size | input | 2 | Operand size of the bus cycle |
| int_data | input | 32 | Internal bus data |
| xa_data | input | 16 | First data-memory bus |
| xb_data | input | 16 | Second data-memory bus |
| lb_data | input | 32 | Local bus data |
| lb_dual_move | input | 1 | Local bus cycle is a dual-memory word move |
| hit_o | output | 1 | Registered break-hit pulse |

## Verification
A register write and a bus compare can land in the same clock. The bench provokes this by presenting a matching bus cycle while it overwrites the break value with a non-matching one. The scoreboard expects a hit for that cycle and no hit for an identical bus cycle one clock later. Back-to-back qualifying cycles are also driven, so that consecutive hit pulses are judged one scoreboard entry each.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    SZ_ANY  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    BUS_INT = 2'b00,
    BUS_UPR = 2'b01,
    BUS_LWR = 2'b10,
    BUS_LOC = 2'b11
  } bus_sel_e;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] val_o,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] val_q, mask_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) mask_q <= wr_data;
      else        val_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_sel ? mask_q : val_q;
  end

  assign rd_data = rd_q;
  assign val_o   = val_q;
  assign mask_o  = mask_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst)) |-> ((($past(wr_sel) ? mask_q : val_q)) == $past(wr_data))); // R2

  AST_UNWRITTEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> ($stable(mask_q) && $stable(val_q))); // R13
endmodule

// File: rtl/brk_lane_sel.sv
module brk_lane_sel
  import brk_pkg::*;
#(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic [1:0]    bus_sel,
  input  logic          dual_move,
  input  logic [DW-1:0] int_data,
  input  logic [HW-1:0] xa_data,
  input  logic [HW-1:0] xb_data,
  input  logic [DW-1:0] lb_data,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] mask,
  output logic          is_wide,
  output logic [DW-1:0] wide_bus,
  output logic [HW-1:0] half_bus,
  output logic [HW-1:0] half_val,
  output logic [HW-1:0] half_mask
);
  logic use_upper;

  always_comb begin
    is_wide   = 1'b0;
    use_upper = 1'b0;
    wide_bus  = '0;
    half_bus  = '0;
    unique case (bus_sel_e'(bus_sel))
      BUS_INT: begin
        is_wide  = 1'b1;
        wide_bus = int_data;
        half_bus = int_data[HW-1:0];
      end
      BUS_UPR: begin
        use_upper = 1'b1;
        half_bus  = xa_data;
      end
      BUS_LWR: begin
        half_bus = xb_data;
      end
      BUS_LOC: begin
        is_wide   = 1'b1;
        use_upper = dual_move;
        wide_bus  = lb_data;
        half_bus  = dual_move ? lb_data[DW-1:HW] : lb_data[HW-1:0];
      end
      default: ;
    endcase
  end

  assign half_val  = use_upper ? val[DW-1:HW]  : val[HW-1:0];
  assign half_mask = use_upper ? mask[DW-1:HW] : mask[HW-1:0];
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int HW = DW / 2,
  localparam int NW = DW / BW,
  localparam int NH = HW / BW
) (
  input  logic [1:0]    size,
  input  logic          is_wide,
  input  logic [DW-1:0] wide_bus,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] mask,
  input  logic [HW-1:0] half_bus,
  input  logic [HW-1:0] half_val,
  input  logic [HW-1:0] half_mask,
  output logic          data_ok
);
  logic [NW-1:0] wide_lane_ok;
  logic [NH-1:0] byte_lane_ok;
  logic          wide_ok, word_ok, byte_ok;

  for (genvar k = 0; k < NW; k++) begin : g_wide
    assign wide_lane_ok[k] =
      ((wide_bus[k*BW +: BW] ^ val[k*BW +: BW]) & ~mask[k*BW +: BW]) == '0;
  end

  for (genvar k = 0; k < NH; k++) begin : g_byte
    assign byte_lane_ok[k] =
      ((half_bus[BW-1:0] ^ half_val[k*BW +: BW]) & ~half_mask[k*BW +: BW]) == '0;
  end

  assign wide_ok = &wide_lane_ok;
  assign word_ok = ((half_bus ^ half_val) & ~half_mask) == '0;
  assign byte_ok = &byte_lane_ok;

  always_comb begin
    unique case (size_e'(size))
      SZ_BYTE: data_ok = byte_ok;
      SZ_WORD: data_ok = word_ok;
      SZ_LONG: data_ok = is_wide ? wide_ok : word_ok;
      default: data_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/brk_data_match.sv
module brk_data_match
  import brk_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic          reg_wr_sel,
  input  logic [DW-1:0] reg_wr_data,
  input  logic          reg_rd_sel,
  output logic [DW-1:0] reg_rd_data,
  input  logic          cfg_data_en,
  input  logic [1:0]    cfg_size,
  input  logic [1:0]    cfg_bus_sel,
  input  logic          bus_valid,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] int_data,
  input  logic [HW-1:0] xa_data,
  input  logic [HW-1:0] xb_data,
  input  logic [DW-1:0] lb_data,
  input  logic          lb_dual_move,
  output logic          hit_o
);
  logic [DW-1:0] val, mask, wide_bus;
  logic [HW-1:0] half_bus, half_val, half_mask;
  logic          is_wide, data_ok, size_ok, data_cond, hit_q;

  brk_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .val_o(val), .mask_o(mask)
  );

  brk_lane_sel #(.DW(DW)) u_lane (
    .bus_sel(cfg_bus_sel), .dual_move(lb_dual_move), .int_data(int_data),
    .xa_data(xa_data), .xb_data(xb_data), .lb_data(lb_data),
    .val(val), .mask(mask), .is_wide(is_wide), .wide_bus(wide_bus),
    .half_bus(half_bus), .half_val(half_val), .half_mask(half_mask)
  );

  brk_match #(.DW(DW), .BW(BW)) u_match (
    .size(cfg_size), .is_wide(is_wide), .wide_bus(wide_bus),
    .val(val), .mask(mask), .half_bus(half_bus), .half_val(half_val),
    .half_mask(half_mask), .data_ok(data_ok)
  );

  assign size_ok   = (size_e'(cfg_size) == SZ_ANY) || (cfg_size == bus_size);
  assign data_cond = cfg_data_en ? data_ok : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= bus_valid && size_ok && data_cond;
  end

  assign hit_o = hit_q;

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(bus_valid)); // R12

  AST_ANY_SIZE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> !($past(cfg_data_en) && $past(cfg_size) == 2'b00)); // R9

  AST_SIZE_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (hit_o && $past(cfg_size) != 2'b00) |-> ($past(bus_size) == $past(cfg_size))); // R10

  AST_FULL_MASKED_EQ: assert property (@(posedge clk) disable iff (rst)
    (hit_o && $past(cfg_data_en) && $past(cfg_size) == 2'b11 && $past(cfg_bus_sel) == 2'b00)
      |-> ((($past(int_data) ^ $past(val)) & ~$past(mask)) == '0)); // R4
endmodule

// File: tb/brk_data_match_test.sv
module brk_data_match_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en, reg_wr_sel, reg_rd_sel;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        cfg_data_en;
  logic [1:0]  cfg_size, cfg_bus_sel, bus_size;
  logic        bus_valid, lb_dual_move, hit_o;
  logic [31:0] int_data, lb_data;
  logic [15:0] xa_data, xb_data;

  always #4 clk = ~clk;

  brk_data_match uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .cfg_data_en(cfg_data_en), .cfg_size(cfg_size), .cfg_bus_sel(cfg_bus_sel),
    .bus_valid(bus_valid), .bus_size(bus_size), .int_data(int_data),
    .xa_data(xa_data), .xb_data(xb_data), .lb_data(lb_data),
    .lb_dual_move(lb_dual_move), .hit_o(hit_o)
  );

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // Monitor: one expected hit bit per driven bus cycle, checked after the edge.
  always @(posedge clk) begin : mon
    item_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (hit_o !== it.exp) begin
        fails++;
        $display("FAIL %s hit_o=%0b expected %0b", it.tag, hit_o, it.exp);
      end
    end
  end

  task automatic drive(input bit v, input logic [1:0] bs, input logic [31:0] fu,
                       input logic [15:0] xa, input logic [15:0] xb,
                       input logic [31:0] lb, input bit du, input bit exp,
                       input string tag);
    item_t it;
    @(negedge clk);
    reg_wr_en    = 1'b0;
    bus_valid    = v;
    bus_size     = bs;
    int_data     = fu;
    xa_data      = xa;
    xb_data      = xb;
    lb_data      = lb;
    lb_dual_move = du;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    bus_valid   = 1'b0;
    reg_wr_en   = 1'b1;
    reg_wr_sel  = sel;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic cfg(input bit en, input logic [1:0] sz, input logic [1:0] sel);
    @(negedge clk);
    bus_valid   = 1'b0;
    cfg_data_en = en;
    cfg_size    = sz;
    cfg_bus_sel = sel;
  endtask

  task automatic chk_rd(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid  = 1'b0;
    reg_rd_sel = sel;
    @(negedge clk);
    checks++;
    if (reg_rd_data !== exp) begin
      fails++;
      $display("FAIL %s reg_rd_data=%h expected %h", tag, reg_rd_data, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = '0; reg_rd_sel = 0;
    cfg_data_en = 0; cfg_size = 0; cfg_bus_sel = 0; bus_valid = 0; bus_size = 0;
    int_data = '0; xa_data = '0; xb_data = '0; lb_data = '0; lb_dual_move = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (hit_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 hit_o=%0b expected 0", hit_o);
    end
    chk_rd(0, 32'h0, "R1 value");
    chk_rd(1, 32'h0, "R1 mask");

    // R2 write and readback
    wr(0, 32'hDEAD_BEEF);
    wr(1, 32'h0000_0000);
    chk_rd(0, 32'hDEAD_BEEF, "R2 value");
    chk_rd(1, 32'h0000_0000, "R2 mask");

    // R4 internal bus, longword
    cfg(1, 2'b11, 2'b00);
    drive(1, 2'b11, 32'hDEAD_BEEF, 0, 0, 0, 0, 1, "R4 full match");
    drive(1, 2'b11, 32'hDEAD_BEEE, 0, 0, 0, 0, 0, "R4 bit0 differs");
    drive(1, 2'b11, 32'h5EAD_BEEF, 0, 0, 0, 0, 0, "R4 bit31 differs");

    // R3 masking
    wr(1, 32'h0000_00FF);
    chk_rd(1, 32'h0000_00FF, "R2 mask write");
    drive(1, 2'b11, 32'hDEAD_BE00, 0, 0, 0, 0, 1, "R3 masked bits ignored");
    drive(1, 2'b11, 32'hDEAD_BF00, 0, 0, 0, 0, 0, "R3 unmasked bit compared");
    wr(1, 32'h0000_0000);

    // R4 internal bus, word uses lower half
    cfg(1, 2'b10, 2'b00);
    drive(1, 2'b10, 32'h1234_BEEF, 0, 0, 0, 0, 1, "R4 word lower half");

    // R9 any size with data enabled
    cfg(1, 2'b00, 2'b00);
    drive(1, 2'b11, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, "R9 any size blocks");

    // R10 size mismatch
    cfg(1, 2'b10, 2'b00);
    drive(1, 2'b11, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, "R10 size mismatch");

    // R5 upper 16-bit bus
    cfg(1, 2'b10, 2'b01);
    drive(1, 2'b10, 0, 16'hDEAD, 16'hBEEF, 0, 0, 1, "R5 upper half match");
    drive(1, 2'b10, 0, 16'hBEEF, 16'hDEAD, 0, 0, 0, "R5 lower half ignored");

    // R6 lower 16-bit bus
    cfg(1, 2'b10, 2'b10);
    drive(1, 2'b10, 0, 16'hDEAD, 16'hBEEF, 0, 0, 1, "R6 lower half match");
    drive(1, 2'b10, 0, 16'hBEEF, 16'hDEAD, 0, 0, 0, "R6 upper half ignored");

    // R7 local bus
    cfg(1, 2'b11, 2'b11);
    drive(1, 2'b11, 0, 0, 0, 32'hDEAD_BEEF, 0, 1, "R7 long match");
    drive(1, 2'b11, 0, 0, 0, 32'hDEAD_BEEA, 0, 0, "R7 long mismatch");
    cfg(1, 2'b10, 2'b11);
    drive(1, 2'b10, 0, 0, 0, 32'h1234_BEEF, 0, 1, "R7 word lower");
    drive(1, 2'b10, 0, 0, 0, 32'hDEAD_0000, 1, 1, "R7 dual move upper");
    drive(1, 2'b10, 0, 0, 0, 32'h1234_BEEF, 1, 0, "R7 dual move ignores lower");

    // R8 byte replicated in both lower bytes
    wr(0, 32'h0000_5A5A);
    cfg(1, 2'b01, 2'b10);
    drive(1, 2'b01, 0, 0, 16'h005A, 0, 0, 1, "R8 byte match");
    drive(1, 2'b01, 0, 0, 16'h005B, 0, 0, 0, "R8 byte mismatch");
    wr(1, 32'h0000_0100);
    drive(1, 2'b01, 0, 0, 16'h005B, 0, 0, 0, "R8 low lane still compared");
    wr(1, 32'h0000_0101);
    drive(1, 2'b01, 0, 0, 16'h005B, 0, 0, 1, "R8 both lanes masked bit0");
    wr(1, 32'h0000_0000);

    // R11 data compare disabled
    cfg(0, 2'b00, 2'b00);
    drive(1, 2'b10, 32'h0BAD_F00D, 0, 0, 0, 0, 1, "R11 data ignored");
    cfg(0, 2'b01, 2'b00);
    drive(1, 2'b10, 32'h0BAD_F00D, 0, 0, 0, 0, 0, "R11 size still required");

    // R12 valid gating and back-to-back pulses
    wr(0, 32'hCAFE_0001);
    cfg(1, 2'b11, 2'b00);
    drive(0, 2'b11, 32'hCAFE_0001, 0, 0, 0, 0, 0, "R12 no valid no hit");
    drive(1, 2'b11, 32'hCAFE_0001, 0, 0, 0, 0, 1, "R12 first pulse");
    drive(1, 2'b11, 32'hCAFE_0001, 0, 0, 0, 0, 1, "R12 second pulse");
    drive(0, 2'b11, 32'hCAFE_0001, 0, 0, 0, 0, 0, "R12 pulse ends");

    // R13 write in the same cycle as a compare
    begin : same_cycle
      item_t it;
      @(negedge clk);
      bus_valid   = 1'b1;
      bus_size    = 2'b11;
      int_data    = 32'hCAFE_0001;
      reg_wr_en   = 1'b1;
      reg_wr_sel  = 1'b0;
      reg_wr_data = 32'h0000_0000;
      it.exp = 1;
      it.tag = "R13 old value used";
      q.push_back(it);
    end
    drive(1, 2'b11, 32'hCAFE_0001, 0, 0, 0, 0, 0, "R13 new value next cycle");
    drive(0, 2'b11, 0, 0, 0, 0, 0, 0, "R13 idle");
    chk_rd(0, 32'h0000_0000, "R13 write landed");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule